// File: doc/BRIEF.md
# Mobile DDR Command Sequencer

This block sits on the controller side of a low-power double-data-rate DRAM. It turns a plain access request into the command stream that the memory expects. A request names the direction, a bank, a row and a column. The sequencer opens the row with an activate command, then issues the column read or write. When the access asks for auto precharge, the column command closes the row. When a later request targets a different row in an open bank, the sequencer closes that bank with a precharge and then opens the new row. The state of every bank is tracked, so several banks can stay open at once and a later access to an open row goes straight to the column command.

The block also runs the start-up sequence and programs the burst length into the mode register. It schedules periodic refresh and handles the two low-power states. Power-down keeps the memory contents. Deep power-down drops them, so leaving it forces a full re-initialisation. All minimum command spacings are parameters counted in clock cycles. The block issues at most one command per cycle, on a registered command bus.

Requests use a valid/ready handshake. `req_valid` must stay high, with all request fields stable, until a cycle in which `req_ready` is high. The request is accepted in that cycle and its column command appears on the command bus one cycle later. `req_ready` is high only in the cycle where the column command for the presented request is chosen. The block withholds it while an activate, a precharge, a refresh or a power state change is still pending, and this is the only form of back-pressure. The block does not carry the data payload. `pd_req` and `dpd_req` are plain level inputs.

Top module: `mddr_cmd_seq`

## Requirements
- R1: During reset and until the start-up sequence finishes, `init_done` is 0, `req_ready` is 0 and the command bus carries NOP. The command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, PALL=5, REF=6, MRS=7, PDE=8, PDX=9, DPDE=10 and DPDX=11. The start-up sequence, issued T_INIT cycles or more after reset, is PALL, REF, REF, MRS. `init_done` rises with the MRS.
- R2: MRS carries the burst code `bl_sel`+1 in `cmd_addr` and bank 0. The code means 1→BL2, 2→BL4, 3→BL8 and 4→BL16. The value of `bl_sel` is latched when MRS is issued.
- R3: A request to a closed bank gives ACT with the bank and the row in `cmd_addr`, then RD (write=0) or WR (write=1) with the column in `cmd_addr`. The column command comes at least T_RCD cycles after the ACT.
- R4: A request to an open bank whose stored row matches gives the column command directly, with no ACT and no PRE.
- R5: A request to an open bank whose stored row differs gives PRE to that bank, then ACT of the new row at least T_RP cycles later, then the column command.
- R6: With `req_autopre`=1, the column command has `cmd_ap`=1 and the bank counts as closed. No PRE is ever issued for that bank afterwards, and the next ACT to it comes at least BL/2+T_RP cycles after the column command.
- R7: Two successive column commands are at least BL/2 cycles apart.
- R8: Activating one bank leaves the other open banks and their rows untouched.
- R9: A refresh becomes due every T_REFI cycles. Once the current wait has elapsed, a due refresh takes priority over power requests and accesses. It gives PALL if any bank is open, then REF.
- R10: With `pd_req` high and nothing due, the block issues PDE and then only NOP. It issues PDX when `pd_req` falls or a refresh becomes due. Bank state survives power-down.
- R11: `dpd_req` gives PALL if any bank is open, then DPDE. When `dpd_req` falls, the block issues DPDX, clears `init_done` and every bank, and repeats the full start-up sequence of R1.
- R12: PRE, RD and WR go only to open banks. REF and DPDE are issued only when every bank is closed.
- R13: Any command after REF comes at least T_RFC cycles later. Any command after PDX comes at least T_XP cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bl_sel | input | 2 | Burst length select, latched at MRS |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after the burst |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| pd_req | input | 1 | Hold the memory in power-down |
| dpd_req | input | 1 | Hold the memory in deep power-down |
| init_done | output | 1 | Start-up sequence complete |
| cmd_o | output | 4 | Command code (see R1) |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row, column or mode value |
| cmd_ap | output | 1 | Auto precharge flag on RD/WR |

## Verification
On every cycle, the in-line properties check the bank-state rules: no precharge or column command to a closed bank, refresh and deep power-down only with every bank closed, and an auto precharge command leaving its bank closed. They also check the minimum activate-to-column, precharge-to-activate and refresh spacings on the registered command bus. The following can only be shown by the bench scenarios, where a model predicts the full command stream: the exact command order, including row hit, row miss and close-then-open, the burst and auto precharge spacing, the refresh taking over from open banks, and bank state surviving power-down but not deep power-down.

// File: rtl/mddr_seq_pkg.sv
package mddr_seq_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_PRE  = 4'd4,
    CMD_PALL = 4'd5,
    CMD_REF  = 4'd6,
    CMD_MRS  = 4'd7,
    CMD_PDE  = 4'd8,
    CMD_PDX  = 4'd9,
    CMD_DPDE = 4'd10,
    CMD_DPDX = 4'd11
  } mddr_cmd_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_INIT_PALL,
    ST_INIT_REF0,
    ST_INIT_REF1,
    ST_INIT_MRS,
    ST_RUN,
    ST_PDOWN,
    ST_DEEP
  } mddr_state_e;

endpackage

// File: rtl/mddr_dncnt.sv
// Loadable down counter that stops at zero; used for command spacing and the refresh interval.
module mddr_dncnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R13: an expired count stays expired until reloaded
  a_r13_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && zero_o) |=> zero_o);

  // R13: a load takes effect on the next cycle
  a_r13_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(val_i)));

endmodule

// File: rtl/mddr_bank_tbl.sv
// Per-bank open flag and open row.
module mddr_bank_tbl #(
  parameter int NBANK = 4,
  parameter int ROW_W = 13,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        act_en,
  input  logic                        close_en,
  input  logic                        clr_en,
  input  logic [BANK_W-1:0]           bank_i,
  input  logic [ROW_W-1:0]            row_i,
  output logic [NBANK-1:0]            open_o,
  output logic [NBANK-1:0][ROW_W-1:0] rows_o
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic             sel;

    assign sel = (bank_i == BANK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (clr_en) begin
        open_q <= 1'b0;
      end else if (act_en && sel) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (close_en && sel) begin
        open_q <= 1'b0;
      end
    end

    assign open_o[b] = open_q;
    assign rows_o[b] = row_q;
  end

  // R5: the sequencer never activates a bank that is already open
  a_r5_act_closed_only: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |-> !open_o[bank_i]);

  // R8: activating one bank leaves every other bank's open flag as it was
  a_r8_act_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && !clr_en) |=> ((open_o | (NBANK'(1) << $past(bank_i))) ==
                             ($past(open_o) | (NBANK'(1) << $past(bank_i)))));

endmodule

// File: rtl/mddr_cmd_seq.sv
module mddr_cmd_seq
  import mddr_seq_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int T_INIT = 200,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 10,
  parameter int T_MRD  = 2,
  parameter int T_XP   = 2,
  parameter int T_REFI = 780,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bl_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_autopre,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              pd_req,
  input  logic              dpd_req,
  output logic              init_done,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ap
);

  localparam int WAIT_W = $clog2(T_INIT + T_RFC + T_RP + T_RCD + T_MRD + T_XP + 16) + 1;
  localparam int REFI_W = $clog2(T_REFI + 1) + 1;

  // ---------------- state ----------------
  mddr_state_e st_q, st_d;
  mddr_cmd_e   cmd_q, n_cmd;
  logic [BANK_W-1:0] bank_q, n_bank;
  logic [ADDR_W-1:0] addr_q, n_addr;
  logic              ap_q, n_ap;
  logic              done_q, done_set, done_clr;
  logic [1:0]        bl_q;
  logic              bl_ld;
  logic              ref_pend_q, ref_clr;

  // ---------------- bank table ----------------
  logic                        tbl_act, tbl_close, tbl_clr;
  logic [NBANK-1:0]            open_vec;
  logic [NBANK-1:0][ROW_W-1:0] rows;

  mddr_bank_tbl #(.NBANK(NBANK), .ROW_W(ROW_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_en   (tbl_act),
    .close_en (tbl_close),
    .clr_en   (tbl_clr),
    .bank_i   (req_bank),
    .row_i    (req_row),
    .open_o   (open_vec),
    .rows_o   (rows)
  );

  // ---------------- command spacing timer ----------------
  logic              w_ld, w_zero;
  logic [WAIT_W-1:0] w_val;

  mddr_dncnt #(.W(WAIT_W)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (w_ld),
    .val_i  (w_val),
    .zero_o (w_zero)
  );

  // ---------------- refresh interval timer ----------------
  logic ref_run, ref_tick, refi_zero, refi_ld;

  assign ref_run  = done_q && (st_q != ST_DEEP);
  assign ref_tick = ref_run && refi_zero;
  assign refi_ld  = !ref_run || ref_clr || ref_tick;

  mddr_dncnt #(.W(REFI_W)) u_refi (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (refi_ld),
    .val_i  (REFI_W'(T_REFI - 1)),
    .zero_o (refi_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ref_pend_q <= 1'b0;
    else if (ref_clr)  ref_pend_q <= 1'b0;
    else if (ref_tick) ref_pend_q <= 1'b1;
  end

  // ---------------- decode helpers ----------------
  logic              any_open, row_hit, bank_open;
  logic [WAIT_W-1:0] half_bl;

  assign any_open  = |open_vec;
  assign bank_open = open_vec[req_bank];
  assign row_hit   = bank_open && (rows[req_bank] == req_row);
  assign half_bl   = WAIT_W'(1) << bl_q;

  // ---------------- next command selection ----------------
  always_comb begin
    st_d      = st_q;
    n_cmd     = CMD_NOP;
    n_bank    = '0;
    n_addr    = '0;
    n_ap      = 1'b0;
    w_ld      = 1'b0;
    w_val     = '0;
    tbl_act   = 1'b0;
    tbl_close = 1'b0;
    tbl_clr   = 1'b0;
    ref_clr   = 1'b0;
    req_ready = 1'b0;
    done_set  = 1'b0;
    done_clr  = 1'b0;
    bl_ld     = 1'b0;

    unique case (st_q)
      ST_BOOT: begin
        w_ld  = 1'b1;
        w_val = WAIT_W'(T_INIT - 1);
        st_d  = ST_INIT_PALL;
      end

      ST_INIT_PALL: if (w_zero) begin
        n_cmd   = CMD_PALL;
        tbl_clr = 1'b1;
        w_ld    = 1'b1;
        w_val   = WAIT_W'(T_RP - 1);
        st_d    = ST_INIT_REF0;
      end

      ST_INIT_REF0, ST_INIT_REF1: if (w_zero) begin
        n_cmd = CMD_REF;
        w_ld  = 1'b1;
        w_val = WAIT_W'(T_RFC - 1);
        st_d  = (st_q == ST_INIT_REF0) ? ST_INIT_REF1 : ST_INIT_MRS;
      end

      ST_INIT_MRS: if (w_zero) begin
        n_cmd    = CMD_MRS;
        n_addr   = ADDR_W'(3'(bl_sel) + 3'd1);
        bl_ld    = 1'b1;
        w_ld     = 1'b1;
        w_val    = WAIT_W'(T_MRD - 1);
        done_set = 1'b1;
        ref_clr  = 1'b1;
        st_d     = ST_RUN;
      end

      ST_RUN: if (w_zero) begin
        if (ref_pend_q || dpd_req) begin
          if (any_open) begin
            n_cmd   = CMD_PALL;
            tbl_clr = 1'b1;
            w_ld    = 1'b1;
            w_val   = WAIT_W'(T_RP - 1);
          end else if (ref_pend_q) begin
            n_cmd   = CMD_REF;
            ref_clr = 1'b1;
            w_ld    = 1'b1;
            w_val   = WAIT_W'(T_RFC - 1);
          end else begin
            n_cmd = CMD_DPDE;
            st_d  = ST_DEEP;
          end
        end else if (pd_req) begin
          n_cmd = CMD_PDE;
          st_d  = ST_PDOWN;
        end else if (req_valid) begin
          n_bank = req_bank;
          if (row_hit) begin
            n_cmd     = req_write ? CMD_WR : CMD_RD;
            n_addr    = ADDR_W'(req_col);
            n_ap      = req_autopre;
            req_ready = 1'b1;
            tbl_close = req_autopre;
            w_ld      = 1'b1;
            w_val     = req_autopre ? (half_bl + WAIT_W'(T_RP - 1)) : (half_bl - 1'b1);
          end else if (bank_open) begin
            n_cmd     = CMD_PRE;
            tbl_close = 1'b1;
            w_ld      = 1'b1;
            w_val     = WAIT_W'(T_RP - 1);
          end else begin
            n_cmd   = CMD_ACT;
            n_addr  = ADDR_W'(req_row);
            tbl_act = 1'b1;
            w_ld    = 1'b1;
            w_val   = WAIT_W'(T_RCD - 1);
          end
        end
      end

      ST_PDOWN: if (w_zero && (!pd_req || ref_pend_q || dpd_req)) begin
        n_cmd = CMD_PDX;
        w_ld  = 1'b1;
        w_val = WAIT_W'(T_XP - 1);
        st_d  = ST_RUN;
      end

      ST_DEEP: if (!dpd_req) begin
        n_cmd    = CMD_DPDX;
        tbl_clr  = 1'b1;
        done_clr = 1'b1;
        w_ld     = 1'b1;
        w_val    = WAIT_W'(T_INIT - 1);
        st_d     = ST_INIT_PALL;
      end

      default: st_d = ST_BOOT;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_BOOT;
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      ap_q   <= 1'b0;
      done_q <= 1'b0;
      bl_q   <= 2'd0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= n_cmd;
      bank_q <= n_bank;
      addr_q <= n_addr;
      ap_q   <= n_ap;
      if (done_set)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (bl_ld) bl_q <= bl_sel;
    end
  end

  assign cmd_o     = cmd_q;
  assign cmd_bank  = bank_q;
  assign cmd_addr  = addr_q;
  assign cmd_ap    = ap_q;
  assign init_done = done_q;

  // ---------------- checks on the command bus ----------------
  logic [NBANK-1:0]  open_prev;
  mddr_cmd_e         last_q;
  logic [WAIT_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_prev <= '0;
      last_q    <= CMD_NOP;
      gap_q     <= '1;
    end else begin
      open_prev <= open_vec;
      if (cmd_q != CMD_NOP) begin
        last_q <= cmd_q;
        gap_q  <= WAIT_W'(1);
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  a_r3_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q inside {CMD_RD, CMD_WR}) && last_q == CMD_ACT) |-> gap_q >= WAIT_W'(T_RCD));

  a_r5_rp_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q inside {CMD_ACT, CMD_REF}) && (last_q inside {CMD_PRE, CMD_PALL}))
      |-> gap_q >= WAIT_W'(T_RP));

  a_r13_rfc_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NOP && last_q == CMD_REF) |-> gap_q >= WAIT_W'(T_RFC));

  a_r12_col_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q inside {CMD_RD, CMD_WR, CMD_PRE}) |-> open_prev[bank_q]);

  a_r12_ref_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q inside {CMD_REF, CMD_DPDE}) |-> (open_prev == '0));

  a_r6_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q inside {CMD_RD, CMD_WR}) && ap_q) |-> !open_vec[bank_q]);

  a_r1_nop_before_init: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !(st_q inside {ST_INIT_MRS, ST_RUN})) |-> (cmd_q inside {CMD_NOP, CMD_PALL, CMD_REF, CMD_DPDX}));

endmodule

// File: tb/mddr_cmd_seq_bench.sv
module mddr_cmd_seq_bench;

  localparam int T_INIT = 20;
  localparam int T_RCD  = 3;
  localparam int T_RP   = 3;
  localparam int T_RFC  = 8;
  localparam int T_MRD  = 2;
  localparam int T_XP   = 2;
  localparam int T_REFI = 2000;

  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_PALL = 5,
                 C_REF = 6, C_MRS = 7, C_PDE = 8, C_PDX = 9, C_DPDE = 10, C_DPDX = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bl_sel = 2'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_autopre = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        pd_req = 1'b0;
  logic        dpd_req = 1'b0;
  logic        init_done;
  logic [3:0]  cmd_o;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;
  logic        cmd_ap;

  mddr_cmd_seq #(
    .NBANK(4), .ROW_W(13), .COL_W(10),
    .T_INIT(T_INIT), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .T_XP(T_XP), .T_REFI(T_REFI)
  ) u_mddr_cmd_seq (
    .clk(clk), .rst_n(rst_n), .bl_sel(bl_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_autopre(req_autopre), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .pd_req(pd_req), .dpd_req(dpd_req),
    .init_done(init_done), .cmd_o(cmd_o), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_ap(cmd_ap)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int half = 4;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- scoreboard ----------------
  logic [19:0] exp_q[$];
  bit          mopen[4];
  int          mrow[4];

  function automatic void push(input int c, input int b, input int a, input bit ap);
    exp_q.push_back({4'(c), 2'(b), 13'(a), ap});
  endfunction

  function automatic string tag_of(input int c);
    case (c)
      C_ACT: return "R3";
      C_RD, C_WR: return "R4";
      C_PRE: return "R5";
      C_PALL, C_REF: return "R9";
      C_MRS: return "R2";
      C_PDE, C_PDX: return "R10";
      default: return "R11";
    endcase
  endfunction

  int  last_c = C_NOP;
  int  last_t = 0;
  bit  ap_pend[4];
  int  ap_t[4];

  always @(negedge clk) begin
    if (rst_n && !finished && cmd_o != 4'(C_NOP)) begin
      automatic int c = int'(cmd_o);
      automatic int g = cyc - last_t;
      automatic logic [19:0] got = {cmd_o, cmd_bank, cmd_addr, cmd_ap};
      if (exp_q.size() == 0) begin
        check(1'b0, tag_of(c), int'(got), -1);
      end else begin
        automatic logic [19:0] e = exp_q.pop_front();
        check(got == e, tag_of(c), int'(got), int'(e));
      end
      if ((c == C_RD || c == C_WR) && last_c == C_ACT) check(g >= T_RCD, "R3 act-to-col", g, T_RCD);
      if (c == C_ACT && (last_c == C_PRE || last_c == C_PALL)) check(g >= T_RP, "R5 pre-to-act", g, T_RP);
      if ((c == C_RD || c == C_WR) && (last_c == C_RD || last_c == C_WR)) check(g >= half, "R7 col-to-col", g, half);
      if (last_c == C_REF) check(g >= T_RFC, "R13 ref gap", g, T_RFC);
      if (last_c == C_PDX) check(g >= T_XP, "R13 pdx gap", g, T_XP);
      if (c == C_ACT && ap_pend[cmd_bank]) begin
        check(cyc - ap_t[cmd_bank] >= half + T_RP, "R6 ap-to-act", cyc - ap_t[cmd_bank], half + T_RP);
        ap_pend[cmd_bank] = 1'b0;
      end
      if ((c == C_RD || c == C_WR) && cmd_ap) begin
        ap_pend[cmd_bank] = 1'b1;
        ap_t[cmd_bank] = cyc;
      end
      last_c = c;
      last_t = cyc;
    end
  end

  // ---------------- driver ----------------
  task automatic access(input bit wr, input bit ap, input int b, input int row, input int col);
    if (mopen[b] && mrow[b] == row) begin
    end else begin
      if (mopen[b]) push(C_PRE, b, 0, 1'b0);
      push(C_ACT, b, row, 1'b0);
    end
    push(wr ? C_WR : C_RD, b, col, ap);
    mopen[b] = !ap;
    mrow[b] = row;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_autopre = ap;
    req_bank = 2'(b); req_row = 13'(row); req_col = 10'(col);
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain(input string tag, input int limit);
    int n = 0;
    while (exp_q.size() != 0 && n < limit) begin
      @(negedge clk);
      n++;
    end
    repeat (T_RFC + 4) @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mopen[i] = 1'b0; mrow[i] = 0; ap_pend[i] = 1'b0; ap_t[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cmd_o == 4'(C_NOP), "R1 reset cmd", int'(cmd_o), C_NOP);
    check(init_done == 1'b0, "R1 reset init_done", int'(init_done), 0);
    check(req_ready == 1'b0, "R1 reset ready", int'(req_ready), 0);
    // R1/R2: start-up sequence with BL8 (code 3)
    push(C_PALL, 0, 0, 1'b0); push(C_REF, 0, 0, 1'b0); push(C_REF, 0, 0, 1'b0); push(C_MRS, 0, 3, 1'b0);
    rst_n = 1'b1;
    repeat (T_INIT - 2) @(negedge clk);
    check(init_done == 1'b0 && cmd_o == 4'(C_NOP), "R1 wait before start-up", int'(cmd_o), C_NOP);
    drain("R1 start-up", 500);
    check(init_done == 1'b1, "R1 init_done", int'(init_done), 1);

    // R3 closed bank, R8 second bank, R4 hit, R7 back-to-back
    access(1'b0, 1'b0, 0, 5, 16);
    access(1'b1, 1'b0, 1, 7, 32);
    access(1'b0, 1'b0, 0, 5, 24);
    access(1'b0, 1'b0, 0, 5, 8);
    // R5 row miss on bank 1
    access(1'b0, 1'b0, 1, 9, 4);
    // R6 auto precharge on bank 2, then reopen
    access(1'b1, 1'b1, 2, 3, 12);
    access(1'b0, 1'b0, 2, 3, 40);
    drain("R4 access stream", 500);

    // R9: banks open when refresh falls due
    push(C_PALL, 0, 0, 1'b0); push(C_REF, 0, 0, 1'b0);
    for (int i = 0; i < 4; i++) mopen[i] = 1'b0;
    drain("R9 refresh with open banks", 3000);

    // R10: refresh during power-down
    pd_req = 1'b1;
    push(C_PDE, 0, 0, 1'b0);
    drain("R10 enter", 100);
    push(C_PDX, 0, 0, 1'b0); push(C_REF, 0, 0, 1'b0); push(C_PDE, 0, 0, 1'b0);
    drain("R10 refresh exit", 3000);
    push(C_PDX, 0, 0, 1'b0);
    pd_req = 1'b0;
    drain("R10 exit", 100);

    // R10: bank state retained across power-down
    access(1'b0, 1'b0, 0, 5, 2);
    drain("R10 open before", 100);
    pd_req = 1'b1;
    push(C_PDE, 0, 0, 1'b0);
    drain("R10 enter2", 100);
    check(req_ready == 1'b0 && cmd_o == 4'(C_NOP), "R10 quiet", int'(cmd_o), C_NOP);
    push(C_PDX, 0, 0, 1'b0);
    pd_req = 1'b0;
    drain("R10 exit2", 100);
    access(1'b0, 1'b0, 0, 5, 6);
    drain("R10 retained row hit", 100);

    // R11: deep power-down with an open bank, re-init with BL16 (code 4)
    dpd_req = 1'b1;
    push(C_PALL, 0, 0, 1'b0); push(C_DPDE, 0, 0, 1'b0);
    for (int i = 0; i < 4; i++) mopen[i] = 1'b0;
    drain("R11 enter", 100);
    bl_sel = 2'd3;
    push(C_DPDX, 0, 0, 1'b0); push(C_PALL, 0, 0, 1'b0); push(C_REF, 0, 0, 1'b0);
    push(C_REF, 0, 0, 1'b0); push(C_MRS, 0, 4, 1'b0);
    dpd_req = 1'b0;
    repeat (3) @(negedge clk);
    check(init_done == 1'b0, "R11 init_done cleared", int'(init_done), 0);
    half = 8;
    drain("R11 re-init", 500);
    check(init_done == 1'b1, "R11 init_done again", int'(init_done), 1);
    // R11: bank table cleared, R7 with BL16
    access(1'b0, 1'b0, 0, 5, 0);
    access(1'b0, 1'b0, 0, 5, 16);
    drain("R11 after re-init", 200);

    check(exp_q.size() == 0, "R12 stream complete", exp_q.size(), 0);
    finish_run();
  end

endmodule